// File: doc/BRIEF.md
# UART Frame Receiver

This block turns an asynchronous serial line back into characters. A free-running enable, `baud_tick`, pulses at OSR times the bit rate, where OSR defaults to 16. The line idles high. A falling edge starts a frame. The receiver then samples the start bit, the data bits, an optional parity bit and one stop bit, each near the middle of its bit period.

The character format comes from static configuration inputs, the same settings a companion transmitter uses:

- a word length of 5, 6, 7 or 8 bits;
- parity on or off;
- an even/odd selector;
- a stick-parity selector that fixes the parity bit to a constant.

Each finished character appears on `rx_data`. It comes with a one-clock `rx_valid` pulse that carries the parity error, framing error and break flags for that same character.

Top module: `uart_frame_rx`

## Requirements
- R1: `rxd` passes through two synchronizing flops. A high-to-low transition of the synchronized line while idle begins a frame. If the line is not low at the (OSR/2)-th tick after the edge, the frame is dropped as a false start and no character is produced.
- R2: Data bits are sampled every OSR ticks after the start-bit sample and assembled least significant bit first. `cfg_wlen` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_data` above the word length are 0.
- R3: When `cfg_par_en` is 1, the bit after the last data bit is taken as parity. When it is 0, no parity bit is expected and `rx_parity_err` is never set.
- R4: With parity enabled and `cfg_stick` = 0, the count of ones over the data bits plus the parity bit must be odd when `cfg_even` = 0 and even when `cfg_even` = 1. Otherwise `rx_parity_err` is set.
- R5: With parity enabled and `cfg_stick` = 1, the parity bit must be 1 when `cfg_even` = 0 and 0 when `cfg_even` = 1. Otherwise `rx_parity_err` is set.
- R6: Only the first stop bit is checked. `rx_frame_err` is set when it samples 0. A new start bit may follow directly after a single stop bit.
- R7: `rx_break` is set, together with `rx_frame_err`, when the start bit, every data bit, the parity bit (if enabled) and the stop bit all sample 0. The receiver then ignores the line until it returns high.
- R8: `rx_valid` is high for exactly one clock per character. The three error flags are high only in that clock, and `rx_data` holds the last character between pulses.
- R9: After reset, `rx_valid`, `rx_data` and all flags are 0 and the receiver is waiting for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock enable at OSR times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Expect and check a parity bit |
| cfg_even | input | 1 | Even parity select; in stick mode, selects a parity bit of 0 |
| cfg_stick | input | 1 | Stick (fixed-value) parity select |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock pulse when a character completes |
| rx_parity_err | output | 1 | Parity mismatch for this character |
| rx_frame_err | output | 1 | First stop bit sampled 0 |
| rx_break | output | 1 | Whole frame sampled 0 |

## Verification
The bench builds the receiver with the default OSR of 16 and pulses `baud_tick` every fourth clock, so one bit spans 64 clocks. That keeps every word length, parity mode and break frame short. It also leaves room for a false-start glitch well under half a bit. The wide tick spacing puts the start edge at different tick phases, which tests that the mid-bit sample stays inside the bit period. Back-to-back frames with a single stop bit and a break held for several bit times cover the stop-bit and line-recovery rules.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_even,
  input  logic       cfg_stick,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_parity_err,
  output logic       rx_frame_err,
  output logic       rx_break
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t           state;
  logic [2:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          par_bit;
  logic          all_low;

  wire       rx_s     = sync[1];
  wire       fall     = sync[2] & ~sync[1];
  wire [2:0] last_idx = {1'b0, cfg_wlen} + 3'd4;
  wire       at_full  = baud_tick && (cnt == CNT_LAST);
  wire       ones     = (^shreg) ^ par_bit;
  wire       par_bad  = cfg_par_en & (cfg_stick ? (par_bit == cfg_even) : (ones ^ ~cfg_even));
  wire       is_brk   = all_low & ~rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      sync          <= '1;
      cnt           <= '0;
      idx           <= '0;
      shreg         <= '0;
      par_bit       <= 1'b0;
      all_low       <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_break      <= 1'b0;
    end else begin
      sync          <= {sync[1:0], rxd};
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_break      <= 1'b0;
      if (baud_tick && state != S_IDLE && state != S_HOLD)
        cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (fall) state <= S_START;
        end
        S_START: if (baud_tick && cnt == CNT_MID) begin
          cnt <= '0;
          if (!rx_s) begin
            state   <= S_DATA;
            idx     <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b1;
          end else begin
            state <= S_IDLE;
          end
        end
        S_DATA: if (at_full) begin
          cnt        <= '0;
          shreg[idx] <= rx_s;
          all_low    <= all_low & ~rx_s;
          idx        <= idx + 1'b1;
          if (idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (at_full) begin
          cnt     <= '0;
          par_bit <= rx_s;
          all_low <= all_low & ~rx_s;
          state   <= S_STOP;
        end
        S_STOP: if (at_full) begin
          cnt           <= '0;
          rx_valid      <= 1'b1;
          rx_data       <= shreg;
          rx_parity_err <= par_bad;
          rx_frame_err  <= ~rx_s;
          rx_break      <= is_brk;
          state         <= is_brk ? S_HOLD : S_IDLE;
        end
        S_HOLD: begin
          cnt <= '0;
          if (rx_s) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_wlen,
  input logic       cfg_par_en,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_parity_err,
  input logic       rx_frame_err,
  input logic       rx_break
);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_flags_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_parity_err || rx_frame_err || rx_break) |-> rx_valid);
  assert_break_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |-> rx_frame_err);
  assert_no_parity_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_err |-> cfg_par_en);
  assert_short_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_wlen == 2'd0) |-> (rx_data[7:5] == 3'd0));
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
  .rx_frame_err(rx_frame_err), .rx_break(rx_break)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int BITC = 64;
  localparam int NV = 9;
  // {wlen, pen, even, stick, data, pbit, stop, exp_data, exp_pe, exp_fe, exp_brk}
  localparam logic [25:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0}, // R2 8N
    {2'd3, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0}, // R4 even ok
    {2'd3, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0}, // R4 even bad
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0}, // R4 odd ok
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0}, // R2 5-bit
    {2'd1, 1'b1, 1'b0, 1'b0, 8'h2A, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b0, 1'b0}, // R4 odd bad 6-bit
    {2'd2, 1'b1, 1'b0, 1'b1, 8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0}, // R5 mark ok
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0}, // R5 space bad
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0}  // R6 framing
  };

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'd3, tdiv = 2'd0;
  logic cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_parity_err, rx_frame_err, rx_break;
  logic baud_tick;
  int checks = 0, fails = 0, n_valid = 0, run = 0, max_run = 0;
  logic [7:0] cap_data = '0;
  logic cap_pe = 1'b0, cap_fe = 1'b0, cap_brk = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
    .cfg_stick(cfg_stick), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_data <= rx_data; cap_pe <= rx_parity_err;
      cap_fe <= rx_frame_err; cap_brk <= rx_break;
      n_valid <= n_valid + 1;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else run <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(input logic [1:0] wl, input logic pen, input logic [7:0] d,
                          input logic pb, input logic stp);
    @(negedge clk);
    hold(1'b0, BITC);
    for (int i = 0; i < int'(wl) + 5; i++) hold(d[i], BITC);
    if (pen) hold(pb, BITC);
    hold(stp, BITC);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pen, input logic ev, input logic st);
    cfg_wlen = wl; cfg_par_en = pen; cfg_even = ev; cfg_stick = st;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    chk("R9 valid", rx_valid, 0);
    chk("R9 data", rx_data, 0);
    chk("R9 flags", {rx_parity_err, rx_frame_err, rx_break}, 0);
    rst_n = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk("R9 idle no output", n_valid, 0);

    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][25:24], VEC[v][23], VEC[v][22], VEC[v][21]);
      n0 = n_valid;
      send_raw(VEC[v][25:24], VEC[v][23], VEC[v][20:13], VEC[v][12], VEC[v][11]);
      hold(1'b1, 2 * BITC);
      chk($sformatf("R8 count vec%0d", v), n_valid, n0 + 1);
      chk($sformatf("R2 data vec%0d", v), cap_data, VEC[v][10:3]);
      chk($sformatf("R4 R5 parity vec%0d", v), cap_pe, VEC[v][2]);
      chk($sformatf("R6 framing vec%0d", v), cap_fe, VEC[v][1]);
      chk($sformatf("R7 break vec%0d", v), cap_brk, VEC[v][0]);
    end
    chk("R8 pulse width", max_run, 1);

    // R1 false start: glitch shorter than half a bit
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    n0 = n_valid;
    @(negedge clk);
    hold(1'b0, 12);
    hold(1'b1, 3 * BITC);
    chk("R1 false start ignored", n_valid, n0);
    send_raw(2'd3, 1'b0, 8'hC3, 1'b0, 1'b1);
    hold(1'b1, 2 * BITC);
    chk("R1 frame after glitch", cap_data, 8'hC3);

    // R6 back-to-back frames with one stop bit
    n0 = n_valid;
    send_raw(2'd3, 1'b0, 8'h11, 1'b0, 1'b1);
    send_raw(2'd3, 1'b0, 8'h22, 1'b0, 1'b1);
    hold(1'b1, 2 * BITC);
    chk("R6 back-to-back count", n_valid, n0 + 2);
    chk("R6 back-to-back data", cap_data, 8'h22);
    chk("R6 back-to-back no fe", cap_fe, 0);

    // R7 break held low, then recovery
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    n0 = n_valid;
    send_raw(2'd3, 1'b1, 8'h00, 1'b0, 1'b0);
    hold(1'b0, 4 * BITC);
    chk("R7 break count", n_valid, n0 + 1);
    chk("R7 break flag", cap_brk, 1);
    chk("R7 break framing", cap_fe, 1);
    chk("R7 break data", cap_data, 0);
    chk("R7 break parity ok", cap_pe, 0);
    hold(1'b1, 2 * BITC);
    chk("R7 no frame while low", n_valid, n0 + 1);
    send_raw(2'd3, 1'b1, 8'h5A, 1'b0, 1'b1);
    hold(1'b1, 2 * BITC);
    chk("R7 recovery data", cap_data, 8'h5A);
    chk("R7 recovery no break", cap_brk, 0);

    // R3 parity off ignores what would be a parity bit slot
    set_cfg(2'd2, 1'b0, 1'b1, 1'b0);
    send_raw(2'd2, 1'b0, 8'h7F, 1'b0, 1'b1);
    hold(1'b1, 2 * BITC);
    chk("R3 no parity data", cap_data, 8'h7F);
    chk("R3 no parity err", cap_pe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule